// File: doc/BRIEF.md
# Interleaved I/Q Symbol Assembler with Table Mapper

This block sits at the input of a digital modulator. Samples arrive one per accepted beat on a single parallel data bus, alternating between the in-phase and quadrature components, so the bus runs at twice the symbol rate. A framing flag tells the block which beats carry an I sample. The block joins each I with the Q that follows it into one quadrature symbol. It places that symbol in a small elastic queue, so that samples can arrive in bursts while symbols still leave at the steady pace the downstream symbol clock asks for.

The downstream side requests one symbol per symbol period. When table mapping is enabled, the low bits of the symbol's I word select an entry in a host-loaded table, and that entry supplies the outgoing I and Q values. Any constellation can be loaded this way. When mapping is disabled, the raw pair leaves unchanged, with the same latency. A plain address/data/strobe port fills the table and may be used while symbols are flowing.

Top module: `sfe_front_end`

## Requirements
- R1: An accepted beat with `in_is_i`=1 followed by an accepted beat with `in_is_i`=0 forms one symbol whose I is the first beat's data and whose Q is the second beat's data.
- R2: When a second I beat is accepted before any Q beat, it replaces the held I. The earlier I is dropped without an error.
- R3: An accepted Q beat with no held I is discarded. `frame_err` is high for exactly the one cycle after the clock edge that accepted it.
- R4: The queue holds 16 symbols. `in_ready` is low exactly while it holds 16, and `in_valid` has no effect while `in_ready` is low.
- R5: A `sym_req` while the queue is non-empty removes the oldest symbol, and `out_valid` is high for the single cycle after that edge with the result on `out_i`/`out_q`. The outputs hold their value at all other times.
- R6: A `sym_req` while the queue is empty raises `underflow` for one cycle after the edge. `out_valid` stays low and the outputs hold.
- R7: With `map_enable`=1, the outputs are the table entry indexed by the low n bits of the symbol's I word (upper index bits zero). n is `idx_bits` limited to the range 2 to 8.
- R8: With `map_enable`=0, the symbol's I and Q leave unchanged, with the same one-cycle latency as in mapped mode.
- R9: A clock edge with `tbl_we`=1 stores `tbl_wdata_i`/`tbl_wdata_q` at `tbl_addr`. A symbol taken on that same edge still sees the old entry, and every later symbol sees the new one.
- R10: After reset, `out_valid`, `underflow` and `frame_err` are low, the outputs are zero, the queue is empty (`in_ready`=1), no I is held and every table entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present on `in_data` |
| in_is_i | input | 1 | 1: beat is an I sample, 0: beat is a Q sample |
| in_data | input | 16 | Sample value |
| in_ready | output | 1 | Queue can take input (not full) |
| sym_req | input | 1 | Downstream symbol request |
| out_valid | output | 1 | New symbol on outputs |
| out_i | output | 16 | Outgoing I value |
| out_q | output | 16 | Outgoing Q value |
| underflow | output | 1 | Request found the queue empty |
| frame_err | output | 1 | Q beat arrived with no I |
| map_enable | input | 1 | 1: table mapping, 0: bypass |
| idx_bits | input | 4 | Number of index bits (limited to 2..8) |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table entry address |
| tbl_wdata_i | input | 16 | I value to store |
| tbl_wdata_q | input | 16 | Q value to store |

## Verification
Directed sequences separate correct pairing from the mistakes a pairing stage can make: a clean I/Q pair, a Q with no I, and two I beats in a row. A random table fill, followed by mapped traffic at index widths of 0, 2, 4, 8 and 15, shows whether index masking and the limits on `idx_bits` are applied, because stray high I bits would select a different entry. A burst that fills the queue and then overruns it, followed by a full drain and one extra request, probes the depth, back-pressure and underflow behaviour. Long random traffic then mixes bursty arrival, framing errors, mode changes and table writes made while symbols flow, so same-edge write/read ordering is exercised many times.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   localparam int unsigned IDX_MIN = 2;

   // Limit a requested index width to the supported range [IDX_MIN, hi].
   function automatic int unsigned clamp_bits(input int unsigned req, input int unsigned hi);
      if (req < IDX_MIN) return IDX_MIN;
      if (req > hi)      return hi;
      return req;
   endfunction
endpackage

// File: rtl/sfe_pairer.sv
module sfe_pairer #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         accept,
   input  logic         is_i,
   input  logic [W-1:0] data,
   output logic         push,
   output logic [W-1:0] push_i,
   output logic [W-1:0] push_q,
   output logic         orphan
);
   logic         have_i;
   logic [W-1:0] held_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_i <= 1'b0;
         held_i <= '0;
      end else if (accept) begin
         if (is_i) begin
            have_i <= 1'b1;
            held_i <= data;
         end else begin
            have_i <= 1'b0;
         end
      end
   end

   always_comb begin
      push   = accept && !is_i && have_i;
      orphan = accept && !is_i && !have_i;
      push_i = held_i;
      push_q = data;
   end
endmodule

// File: rtl/sfe_fifo.sv
module sfe_fifo #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] level
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfe_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_comb begin
      head  = mem[rd_ptr];
      full  = (count == CW'(DEPTH));
      empty = (count == '0);
      level = count;
   end
endmodule

// File: rtl/sfe_mapper.sv
module sfe_mapper
   import sfe_pkg::*;
#(
   parameter int unsigned W   = 16,
   parameter int unsigned AW  = 8,
   localparam int unsigned ENTRIES = 1 << AW,
   localparam int unsigned BW      = $clog2(AW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pop,
   input  logic [W-1:0]  sym_i,
   input  logic [W-1:0]  sym_q,
   input  logic          map_enable,
   input  logic [BW-1:0] idx_bits,
   input  logic          tbl_we,
   input  logic [AW-1:0] tbl_addr,
   input  logic [W-1:0]  tbl_wdata_i,
   input  logic [W-1:0]  tbl_wdata_q,
   output logic          out_valid,
   output logic [W-1:0]  out_i,
   output logic [W-1:0]  out_q
);
   if (AW > W || AW < IDX_MIN) begin : g_bad_aw
      $error("sfe_mapper: AW must lie between IDX_MIN and W");
   end

   logic [W-1:0]       tab_i [ENTRIES];
   logic [W-1:0]       tab_q [ENTRIES];
   logic [ENTRIES-1:0] hit;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_dec
      assign hit[e] = tbl_we && (tbl_addr == AW'(e));
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < ENTRIES; e++) begin
         if (!rst_n) begin
            tab_i[e] <= '0;
            tab_q[e] <= '0;
         end else if (hit[e]) begin
            tab_i[e] <= tbl_wdata_i;
            tab_q[e] <= tbl_wdata_q;
         end
      end
   end

   int unsigned   eff_bits;
   logic [AW-1:0] mask, index;
   logic [W-1:0]  sel_i, sel_q;

   always_comb begin
      eff_bits = clamp_bits(int'(idx_bits), AW);
      mask     = ~({AW{1'b1}} << eff_bits);
      index    = sym_i[AW-1:0] & mask;
      if (map_enable) begin
         sel_i = tab_i[index];
         sel_q = tab_q[index];
      end else begin
         sel_i = sym_i;
         sel_q = sym_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= pop;
         if (pop) begin
            out_i <= sel_i;
            out_q <= sel_q;
         end
      end
   end
endmodule

// File: rtl/sfe_front_end.sv
module sfe_front_end #(
   parameter int unsigned SAMPLE_W   = 16,
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned MAP_AW     = 8,
   localparam int unsigned IDX_W     = $clog2(MAP_AW + 1),
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                in_is_i,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                in_ready,
   input  logic                sym_req,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_i,
   output logic [SAMPLE_W-1:0] out_q,
   output logic                underflow,
   output logic                frame_err,
   input  logic                map_enable,
   input  logic [IDX_W-1:0]    idx_bits,
   input  logic                tbl_we,
   input  logic [MAP_AW-1:0]   tbl_addr,
   input  logic [SAMPLE_W-1:0] tbl_wdata_i,
   input  logic [SAMPLE_W-1:0] tbl_wdata_q
);
   logic                  accept, push, orphan, pop, full, empty;
   logic [SAMPLE_W-1:0]   push_i, push_q;
   logic [2*SAMPLE_W-1:0] head;
   logic [LVL_W-1:0]      fifo_level;

   assign in_ready = !full;
   assign accept   = in_valid && in_ready;
   assign pop      = sym_req && !empty;

   sfe_pairer #(.W(SAMPLE_W)) u_pair (
      .clk(clk), .rst_n(rst_n), .accept(accept), .is_i(in_is_i), .data(in_data),
      .push(push), .push_i(push_i), .push_q(push_q), .orphan(orphan)
   );

   sfe_fifo #(.DW(2*SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata({push_i, push_q}),
      .pop(pop), .head(head), .full(full), .empty(empty), .level(fifo_level)
   );

   sfe_mapper #(.W(SAMPLE_W), .AW(MAP_AW)) u_map (
      .clk(clk), .rst_n(rst_n), .pop(pop),
      .sym_i(head[2*SAMPLE_W-1:SAMPLE_W]), .sym_q(head[SAMPLE_W-1:0]),
      .map_enable(map_enable), .idx_bits(idx_bits),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_wdata_i(tbl_wdata_i), .tbl_wdata_q(tbl_wdata_q),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         underflow <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         underflow <= sym_req && empty;
         frame_err <= orphan;
      end
   end
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_is_i,
   input logic          in_ready,
   input logic          sym_req,
   input logic          out_valid,
   input logic          underflow,
   input logic          frame_err,
   input logic [W-1:0]  out_i,
   input logic [W-1:0]  out_q,
   input logic [CW-1:0] level
);
   a_r5_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(sym_req));

   a_r6_underflow_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> $past(sym_req));

   a_r6_no_data_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> !out_valid);

   a_r3_err_from_q_beat: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> $past(in_valid && in_ready && !in_is_i));

   a_r5_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_i) && $stable(out_q)));

   a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));

   a_r4_no_growth_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> level <= $past(level));
endmodule

bind sfe_front_end sfe_checker #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH), .CW(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_i(in_is_i),
   .in_ready(in_ready), .sym_req(sym_req), .out_valid(out_valid),
   .underflow(underflow), .frame_err(frame_err), .out_i(out_i), .out_q(out_q),
   .level(fifo_level)
);

// File: tb/tb_sfe_front_end.sv
module tb_sfe_front_end;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_is_i = 1'b0, sym_req = 1'b0;
   logic [15:0] in_data = '0;
   logic        map_enable = 1'b0, tbl_we = 1'b0;
   logic [3:0]  idx_bits = 4'd8;
   logic [7:0]  tbl_addr = '0;
   logic [15:0] tbl_wdata_i = '0, tbl_wdata_q = '0;
   logic        in_ready, out_valid, underflow, frame_err;
   logic [15:0] out_i, out_q;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sfe_front_end dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_i(in_is_i),
      .in_data(in_data), .in_ready(in_ready), .sym_req(sym_req),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
      .underflow(underflow), .frame_err(frame_err), .map_enable(map_enable),
      .idx_bits(idx_bits), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_wdata_i(tbl_wdata_i), .tbl_wdata_q(tbl_wdata_q)
   );

   // Reference model state
   logic [31:0] mq[$];
   logic [15:0] m_tab_i [256];
   logic [15:0] m_tab_q [256];
   bit          m_have_i = 0;
   logic [15:0] m_held = '0;
   logic [15:0] e_oi = '0, e_oq = '0;

   function automatic logic [31:0] exp_map(logic [31:0] s, logic me, logic [3:0] b);
      int eb  = (b < 2) ? 2 : ((b > 8) ? 8 : int'(b));
      int idx = int'(s[23:16]) & ((1 << eb) - 1);
      return me ? {m_tab_i[idx], m_tab_q[idx]} : s;
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // One clock: inputs already driven; model pre-edge, then compare after edge.
   task automatic cycle(string tag);
      bit acc, pop, uf, fe;
      logic [31:0] r;
      chk(in_ready == (mq.size() < 16), {tag, " R4 in_ready"}, 32'(in_ready), 32'(mq.size() < 16));
      acc = in_valid && (mq.size() < 16);
      pop = sym_req && (mq.size() > 0);
      uf  = sym_req && (mq.size() == 0);
      if (pop) begin
         r = exp_map(mq.pop_front(), map_enable, idx_bits);
         e_oi = r[31:16];
         e_oq = r[15:0];
      end
      fe = acc && !in_is_i && !m_have_i;
      if (acc) begin
         if (in_is_i) begin m_have_i = 1; m_held = in_data; end
         else begin
            if (m_have_i) mq.push_back({m_held, in_data});
            m_have_i = 0;
         end
      end
      if (tbl_we) begin m_tab_i[tbl_addr] = tbl_wdata_i; m_tab_q[tbl_addr] = tbl_wdata_q; end
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == pop, {tag, " R5 out_valid"}, 32'(out_valid), 32'(pop));
      chk(underflow == uf, {tag, " R6 underflow"}, 32'(underflow), 32'(uf));
      chk(frame_err == fe, {tag, " R3 frame_err"}, 32'(frame_err), 32'(fe));
      chk({out_i, out_q} == {e_oi, e_oq}, {tag, " R7/R8 data"}, {out_i, out_q}, {e_oi, e_oq});
   endtask

   task automatic drive(bit v, bit isi, logic [15:0] d, bit rq, string tag);
      in_valid = v; in_is_i = isi; in_data = d; sym_req = rq; tbl_we = 0;
      cycle(tag);
   endtask

   task automatic wr(logic [7:0] a, logic [15:0] wi, logic [15:0] wq, string tag);
      in_valid = 0; sym_req = 0; tbl_we = 1; tbl_addr = a; tbl_wdata_i = wi; tbl_wdata_q = wq;
      cycle(tag);
      tbl_we = 0;
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      end
      $finish;
   end

   initial begin
      bit nexti;
      void'($urandom(32'd7321));
      for (int k = 0; k < 256; k++) begin m_tab_i[k] = '0; m_tab_q[k] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10: reset state
      chk(out_valid == 0 && underflow == 0 && frame_err == 0, "R10 flags", {29'd0, out_valid, underflow, frame_err}, 0);
      chk({out_i, out_q} == 0, "R10 outputs", {out_i, out_q}, 0);
      chk(in_ready == 1, "R10 in_ready", 32'(in_ready), 1);
      drive(0, 0, 0, 1, "R10 R6 empty after reset");
      // R1/R8: pairing in bypass
      drive(1, 1, 16'h1234, 0, "R1 I beat");
      drive(1, 0, 16'hABCD, 0, "R1 Q beat");
      drive(0, 0, 0, 1, "R1 R8 pop");
      // R3: orphan Q
      drive(1, 0, 16'h5555, 0, "R3 orphan");
      drive(0, 0, 0, 1, "R3 nothing queued");
      // R2: I,I,Q
      drive(1, 1, 16'h1111, 0, "R2 first I");
      drive(1, 1, 16'h2222, 0, "R2 second I");
      drive(1, 0, 16'h3333, 0, "R2 Q");
      drive(0, 0, 0, 1, "R2 pop");
      // R10: table zero after reset, mapped mode
      map_enable = 1; idx_bits = 8;
      drive(1, 1, 16'h00A7, 0, "R10 I");
      drive(1, 0, 16'h0001, 0, "R10 Q");
      drive(0, 0, 0, 1, "R10 zero table");
      // R9: load table
      for (int k = 0; k < 256; k++) wr(8'(k), 16'($urandom), 16'($urandom), "R9 load");
      // R4: fill and overrun
      map_enable = 0;
      for (int k = 0; k < 17; k++) begin
         drive(1, 1, 16'(k * 3 + 1), 0, "R4 fill I");
         drive(1, 0, 16'(k * 5 + 2), 0, "R4 fill Q");
      end
      for (int k = 0; k < 17; k++) drive(0, 0, 0, 1, "R4 R6 drain");
      // R7: mapped traffic across index widths
      map_enable = 1;
      foreach (idx_bits_list[j]) begin
         idx_bits = idx_bits_list[j];
         for (int k = 0; k < 12; k++) begin
            drive(1, 1, 16'($urandom), 0, "R7 I");
            drive(1, 0, 16'($urandom), 0, "R7 Q");
            drive(0, 0, 0, 1, "R7 pop");
         end
      end
      // R9: write on the same edge as a pop, then again
      idx_bits = 8;
      drive(1, 1, 16'h0042, 0, "R9 I");
      drive(1, 0, 16'h0000, 0, "R9 Q");
      drive(1, 1, 16'h0042, 0, "R9 I2");
      drive(1, 0, 16'h0000, 0, "R9 Q2");
      in_valid = 0; sym_req = 1; tbl_we = 1; tbl_addr = 8'h42; tbl_wdata_i = 16'hBEEF; tbl_wdata_q = 16'hCAFE;
      cycle("R9 same-edge old entry");
      drive(0, 0, 0, 1, "R9 next symbol new entry");
      // Random mixed traffic
      nexti = 1;
      for (int k = 0; k < 4000; k++) begin
         in_valid = ($urandom % 4) != 0;
         in_is_i  = (($urandom % 10) == 0) ? !nexti : nexti;
         in_data  = 16'($urandom);
         sym_req  = ($urandom % 3) == 0 || (k % 800) > 600;
         tbl_we   = ($urandom % 8) == 0;
         tbl_addr = 8'($urandom);
         tbl_wdata_i = 16'($urandom);
         tbl_wdata_q = 16'($urandom);
         if ((k % 500) == 0) begin map_enable = 1'($urandom); idx_bits = 4'($urandom); end
         if (in_valid && in_ready) nexti = !in_is_i;
         cycle("R1-mix");
      end
      tbl_we = 0; in_valid = 0; sym_req = 0;
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      end
      $finish;
   end

   logic [3:0] idx_bits_list [5] = '{4'd0, 4'd2, 4'd4, 4'd8, 4'd15};
endmodule